// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block computes the arithmetic and logic results for a small processor built around an 8-bit accumulator. Each cycle in which `op_valid` is high, the block takes the current accumulator value, one second operand byte and the instruction's opcode. It then registers the new accumulator value together with an updated flag byte. The processor's fetch and operand-selection logic chooses the second operand, which may come from a register, an immediate or memory. The block only sees the byte that was picked, so the low three opcode bits of the two-operand groups do not affect it.

The flag register lives inside the block, and every operation works from its current content. The block sets the sign, zero and parity flags that the branch logic tests. It also keeps a carry flag and a half-carry flag, which add, subtract and decimal adjust use. The whole flag byte can be copied into the accumulator and loaded back from it. An opcode that the block does not handle leaves all of its state unchanged. The sequencer can therefore pulse `op_valid` on every instruction without decoding first.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out`, `acc_wr` and `flags` all become 0.
- R2: The flag byte is laid out as sign=bit7, zero=bit6, half-carry=bit5, parity=bit2 and carry=bit0. Bits 4, 3 and 1 always read 0, so the byte never has bits outside mask 0xE5. The parity flag is 1 when the result has an odd number of one bits.
- R3: Opcodes 0x80–0x97 perform AND (bits[5:3]=0), OR (1) or XOR (2) of the accumulator with `opnd`. These operations clear carry and leave half-carry unchanged.
- R4: Opcodes 0xA0–0xA7 add `opnd` and ignore the incoming carry. Opcodes 0xA8–0xAF add `opnd` plus the carry. Carry becomes the carry out of bit 7, and half-carry becomes the carry out of bit 3.
- R5: Opcodes 0xB0–0xB7 subtract `opnd`. Opcodes 0xB8–0xBF subtract `opnd` and the carry. Carry is 1 on a borrow out of bit 7, and half-carry is 1 on a borrow out of bit 3.
- R6: Opcodes 0x98, 0x99, 0x9A and 0x9B rotate the accumulator left, left through carry, right and right through carry. The through-carry forms move the bit that leaves the accumulator into carry. The plain forms leave carry unchanged.
- R7: Opcode 0x9E increments the accumulator, 0x9F decrements it and 0x0F inverts it. None of the three changes carry or half-carry.
- R8: Opcodes 0x08, 0x09 and 0x0E set, clear and invert carry. They change no other flag and do not write the accumulator.
- R9: Opcode 0xFA decimal-adjusts the accumulator. It first adds 0x06 when the low nibble is above 9 or half-carry is set. It then adds 0x60 when the high nibble of that sum is above 9, the first step overflowed, or carry is set. Carry ends up as the old carry ORed with the overflow of either step.
- R10: Opcode 0x11 writes the flag byte into the accumulator. Opcode 0x12 loads the flags from the accumulator masked by 0xE5 and does not write the accumulator.
- R11: Every operation that writes the accumulator sets zero, sign and parity from the new accumulator value.
- R12: When `op_valid` is low, or the opcode is not one listed above (for example 0x00, 0x9C or 0xFF), `acc_wr` is 0 and both `acc_out` and `flags` keep their values.
- R13: Results appear on the clock edge that samples `op_valid` high. `acc_wr` is a one-cycle pulse for each operation that writes the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute the opcode on this edge |
| opcode | input | 8 | Instruction opcode |
| acc_in | input | 8 | Current accumulator value |
| opnd | input | 8 | Selected second operand byte |
| acc_out | output | 8 | Registered new accumulator value |
| acc_wr | output | 1 | Accumulator write pulse |
| flags | output | 8 | Registered flag byte |

## Verification
On every cycle, the assertions check the following: the unused flag bits stay 0, idle cycles leave all state frozen, and the carry set, carry clear and flag load opcodes land on the next edge. They also check that zero, sign and parity agree with the accumulator whenever it is written. Arithmetic values are checked only by the bench's scenarios, which preload the flags and then run each operation. These scenarios cover carry and half-carry out of each nibble, borrow, the through-carry rotates, both steps of decimal adjust and the flag-to-accumulator copy.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW    = 8;
  localparam int NIB   = DW / 2;
  localparam int FB_C  = 0;
  localparam int FB_P  = 2;
  localparam int FB_H  = 5;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;
  localparam logic [DW-1:0] FLAG_MASK = (DW'(1) << FB_C) | (DW'(1) << FB_P) |
                                        (DW'(1) << FB_H) | (DW'(1) << FB_Z) |
                                        (DW'(1) << FB_S);

  typedef enum logic [4:0] {
    K_NONE, K_AND, K_OR, K_XOR, K_ADD, K_ADDC, K_SUB, K_SUBB,
    K_RL, K_RLC, K_RR, K_RRC, K_INC, K_DEC, K_CPL,
    K_SETC, K_CLRC, K_CPLC, K_DA, K_SFA, K_LAF
  } alu_kind_e;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [7:0] opcode,
  output alu_kind_e  kind
);
  always_comb begin
    kind = K_NONE;
    if (opcode[7:6] == 2'b10) begin
      case (opcode[5:3])
        3'd0: kind = K_AND;
        3'd1: kind = K_OR;
        3'd2: kind = K_XOR;
        3'd3: begin
          case (opcode[2:0])
            3'd0:    kind = K_RL;
            3'd1:    kind = K_RLC;
            3'd2:    kind = K_RR;
            3'd3:    kind = K_RRC;
            3'd6:    kind = K_INC;
            3'd7:    kind = K_DEC;
            default: kind = K_NONE;
          endcase
        end
        3'd4: kind = K_ADD;
        3'd5: kind = K_ADDC;
        3'd6: kind = K_SUB;
        default: kind = K_SUBB;
      endcase
    end else begin
      case (opcode)
        8'h08:   kind = K_SETC;
        8'h09:   kind = K_CLRC;
        8'h0E:   kind = K_CPLC;
        8'h0F:   kind = K_CPL;
        8'h11:   kind = K_SFA;
        8'h12:   kind = K_LAF;
        8'hFA:   kind = K_DA;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  alu_kind_e        kind,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [DW-1:0]    fin,
  output logic [DW-1:0]    res,
  output logic             wr,
  output logic [DW-1:0]    fout
);
  logic          cin, c, h, ci;
  logic [DW:0]   sum, t1, t2;
  logic [NIB:0]  lo;
  logic          adj2;

  assign cin = fin[FB_C];

  always_comb begin
    res  = a;
    wr   = 1'b0;
    c    = cin;
    h    = fin[FB_H];
    ci   = 1'b0;
    sum  = '0;
    lo   = '0;
    t1   = '0;
    t2   = '0;
    adj2 = 1'b0;
    case (kind)
      K_AND: begin res = a & b; wr = 1'b1; c = 1'b0; end
      K_OR:  begin res = a | b; wr = 1'b1; c = 1'b0; end
      K_XOR: begin res = a ^ b; wr = 1'b1; c = 1'b0; end
      K_ADD, K_ADDC: begin
        ci  = (kind == K_ADDC) & cin;
        sum = {1'b0, a} + {1'b0, b} + (DW+1)'(ci);
        lo  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + (NIB+1)'(ci);
        res = sum[DW-1:0]; c = sum[DW]; h = lo[NIB]; wr = 1'b1;
      end
      K_SUB, K_SUBB: begin
        ci  = (kind == K_SUBB) & cin;
        sum = {1'b0, a} - {1'b0, b} - (DW+1)'(ci);
        lo  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - (NIB+1)'(ci);
        res = sum[DW-1:0]; c = sum[DW]; h = lo[NIB]; wr = 1'b1;
      end
      K_RL:  begin res = {a[DW-2:0], a[DW-1]}; wr = 1'b1; end
      K_RLC: begin res = {a[DW-2:0], cin}; c = a[DW-1]; wr = 1'b1; end
      K_RR:  begin res = {a[0], a[DW-1:1]}; wr = 1'b1; end
      K_RRC: begin res = {cin, a[DW-1:1]}; c = a[0]; wr = 1'b1; end
      K_INC: begin res = a + DW'(1); wr = 1'b1; end
      K_DEC: begin res = a - DW'(1); wr = 1'b1; end
      K_CPL: begin res = ~a; wr = 1'b1; end
      K_SETC: c = 1'b1;
      K_CLRC: c = 1'b0;
      K_CPLC: c = ~cin;
      K_DA: begin
        t1   = {1'b0, a} + (((a[NIB-1:0] > NIB'(9)) || fin[FB_H]) ? (DW+1)'(6) : '0);
        adj2 = t1[DW] | (t1[DW-1:NIB] > NIB'(9)) | cin;
        t2   = {1'b0, t1[DW-1:0]} + (adj2 ? (DW+1)'(8'h60) : '0);
        res  = t2[DW-1:0];
        c    = cin | t1[DW] | t2[DW];
        wr   = 1'b1;
      end
      K_SFA: begin res = fin & FLAG_MASK; wr = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    if (kind == K_LAF) begin
      fout = a & FLAG_MASK;
    end else begin
      fout        = '0;
      fout[FB_C]  = c;
      fout[FB_H]  = h;
      fout[FB_S]  = wr ? res[DW-1]  : fin[FB_S];
      fout[FB_Z]  = wr ? (res == '0) : fin[FB_Z];
      fout[FB_P]  = wr ? (^res)      : fin[FB_P];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] acc_out,
  output logic          acc_wr,
  output logic [DW-1:0] flags
);
  alu_kind_e     kind;
  logic [DW-1:0] res_d, flags_d;
  logic          wr_d;

  alu_decode u_dec (
    .opcode (opcode),
    .kind   (kind)
  );

  alu_datapath u_dp (
    .kind (kind),
    .a    (acc_in),
    .b    (opnd),
    .fin  (flags),
    .res  (res_d),
    .wr   (wr_d),
    .fout (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      acc_wr  <= 1'b0;
      flags   <= '0;
    end else if (op_valid) begin
      flags  <= flags_d;
      acc_wr <= wr_d;
      if (wr_d) acc_out <= res_d;
    end else begin
      acc_wr <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import alu_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [7:0]    opcode,
  input logic [DW-1:0] acc_in,
  input logic [DW-1:0] acc_out,
  input logic          acc_wr,
  input logic [DW-1:0] flags
);
  p_flag_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (flags & ~FLAG_MASK) == '0);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!acc_wr && $stable(flags) && $stable(acc_out)));

  p_set_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode == 8'h08) |=> (flags[FB_C] && !acc_wr));

  p_clr_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode == 8'h09) |=> (!flags[FB_C] && !acc_wr));

  p_flag_load_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode == 8'h12) |=> (flags == ($past(acc_in) & FLAG_MASK)));

  p_zero_flag_r11: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> (flags[FB_Z] == (acc_out == '0)));

  p_parity_flag_r11: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> (flags[FB_P] == (^acc_out)));

  p_sign_flag_r11: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> (flags[FB_S] == acc_out[DW-1]));
endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] opcode = 8'h00, acc_in = 8'h00, opnd = 8'h00;
  logic [7:0] acc_out, flags;
  logic       acc_wr;
  int         errors = 0, checks = 0;

  always #2 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
    .acc_in(acc_in), .opnd(opnd), .acc_out(acc_out), .acc_wr(acc_wr),
    .flags(flags)
  );

  // {opcode, acc_in, opnd, preload flags, expected acc, expected wr, expected flags}
  localparam int NV = 26;
  localparam logic [55:0] VEC [NV] = '{
    56'h80_F0_3C_21_30_01_20, 56'h8E_0F_80_00_8F_01_84, 56'h95_5A_5A_01_00_01_40,
    56'hA6_8F_81_01_10_01_25, 56'hAE_0F_00_01_10_01_24, 56'hB6_10_01_01_0F_01_20,
    56'hBE_00_00_01_FF_01_A1, 56'hB0_42_42_00_00_01_40, 56'h98_81_00_00_03_01_00,
    56'h99_80_00_00_00_01_41, 56'h9A_01_00_01_80_01_85, 56'h9B_02_00_01_81_01_80,
    56'h9E_FF_00_21_00_01_61, 56'h9F_00_00_00_FF_01_80, 56'h0F_55_00_01_AA_01_81,
    56'h08_00_00_44_00_00_45, 56'h09_00_00_E5_00_00_E4, 56'h0E_00_00_04_00_00_05,
    56'hFA_9A_00_00_00_01_41, 56'hFA_15_00_20_1B_01_20, 56'hFA_38_00_01_98_01_85,
    56'h11_00_00_E5_E5_01_A5, 56'h12_FF_00_00_00_00_E5, 56'h9C_12_00_25_00_00_25,
    56'h00_33_00_81_00_00_81, 56'hFF_77_00_44_00_00_44
  };

  function automatic string tag_of(input logic [7:0] op);
    if (op >= 8'h80 && op <= 8'h97) return "R3";
    if (op >= 8'hA0 && op <= 8'hAF) return "R4";
    if (op >= 8'hB0 && op <= 8'hBF) return "R5";
    if (op >= 8'h98 && op <= 8'h9B) return "R6";
    if (op == 8'h9E || op == 8'h9F || op == 8'h0F) return "R7";
    if (op == 8'h08 || op == 8'h09 || op == 8'h0E) return "R8";
    if (op == 8'hFA) return "R9";
    if (op == 8'h11 || op == 8'h12) return "R10";
    return "R12";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // drive one operation at a falling edge; outputs are read at the next falling edge
  task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; acc_in = a; opnd = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1", "acc_out after reset", acc_out, 8'h00);
    check("R1", "acc_wr after reset", {7'd0, acc_wr}, 8'h00);
    check("R1", "flags after reset", flags, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] op, a, b, fi, ea, ew, ef;
      {op, a, b, fi, ea, ew, ef} = VEC[i];
      issue(8'h12, fi, 8'h00);
      held = acc_out;
      issue(op, a, b);
      check(tag_of(op), "acc_wr", {7'd0, acc_wr}, ew);
      check(tag_of(op), "flags", flags, ef);
      if (ew[0]) check(tag_of(op), "acc_out", acc_out, ea);
      else       check("R12", "acc_out held", acc_out, held);
    end

    // R2: loading all ones keeps only the defined flag bits
    issue(8'h12, 8'hFF, 8'h00);
    check("R2", "flag mask", flags, 8'hE5);

    // R11: sign and parity from an add result of 0x80
    issue(8'h12, 8'h00, 8'h00);
    issue(8'hA2, 8'h7F, 8'h01);
    check("R11", "add to 0x80 flags", flags, 8'hA4);
    check("R11", "add to 0x80 value", acc_out, 8'h80);

    // R13: write pulse lasts one cycle
    @(negedge clk);
    check("R13", "acc_wr after idle cycle", {7'd0, acc_wr}, 8'h00);
    check("R13", "acc_out held after pulse", acc_out, 8'h80);

    // R12: carry set opcode presented without op_valid
    @(negedge clk);
    op_valid = 1'b0; opcode = 8'h08; acc_in = 8'h00;
    @(negedge clk);
    check("R12", "flags with op_valid low", flags, 8'hA4);
    check("R12", "acc_wr with op_valid low", {7'd0, acc_wr}, 8'h00);

    // R1: reset in mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "acc_out after second reset", acc_out, 8'h00);
    check("R1", "flags after second reset", flags, 8'h00);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule